// File: doc/BRIEF.md
# Banked Sensor Configuration Register File

This block is the register file of an inertial sensor, placed behind whatever serial port decoder (two-wire or four-wire) turns bus traffic into single-cycle register reads and writes. It stores the configuration bytes and serves the read-only identity and sample bytes. It drives the two interrupt pins. It has one general register bank and three special banks. A special bank opens when a key value is written to a fixed bank-select address, and the general bank returns when a zero is written there.

The sample bytes arrive from the sensor datapath as 16-bit high/low pairs. An optional block-update mode keeps a pair frozen until software has read both halves, so the two bytes always come from the same sample. Each interrupt pin has a 5-bit source code that picks one internal event flag, or a fixed OR of two flags. Both pins share one polarity bit and one push-pull/open-drain bit. A self-clearing reload bit starts a timed reload that returns the special-bank registers to their defaults.

Top module: `sensor_regfile`

## Requirements
- R1: After synchronous reset the general bank is selected, and reads return 0x50 at 0x05, 0x80 at 0x08, 0x07 at 0x1D, 0xFF at 0x1E, 0xA8 at 0x40, 0x02 at 0x41 and 0xA9 at 0x42. Other writable registers return 0x00, both interrupt pins are inactive, and address auto-increment (0x05 bit 4) reads 1.
- R2: In the general bank, address 0x01 always reads 0x6A, and writes to it are ignored.
- R3: A write to 0x7F of 0x83, 0x8C or 0x90 selects special bank 1, 2 or 3, and a write of 0x00 selects the general bank. Any other value leaves the bank unchanged. Address 0x7F is reachable from every bank and reads back the key of the current bank.
- R4: Special bank 1 holds one register at 0x6F (default 0x00), bank 2 holds one at 0x30 (default 0x00), and bank 3 holds four at 0x40 to 0x43 (defaults 0x52, 0x9A, 0x04, 0x57). These registers have storage separate from the general registers at the same addresses.
- R5: Writes to read-only or unmapped addresses of the current bank are ignored, and reads of unmapped addresses return 0x00. The identity and sample bytes exist only in the general bank.
- R6: Writing 0x05 with bit 7 set, while no reload is running, makes bit 7 (and cfg_reload) read 1 for RELOAD_CYCLES cycles, after which it clears. In the last of those cycles every special-bank register returns to its default. Bits 6:0 take the written value.
- R7: Register 0x05 drives the block-update enable from bit 5, auto-increment from bit 4, the secondary-port 3-wire select from bit 1 and the primary 3-wire select from bit 0.
- R8: Sample pair p reads at 0x0C+2p (high byte) and 0x0D+2p (low byte). Pair p is taken from smp_data[16p+15:16p]. With block-update off, every smp_update pulse refreshes all pairs.
- R9: With block-update on, a pair that was refreshed is not refreshed again until both of its bytes have been read in the general bank.
- R10: Register 0x06 bits 4:0 and register 0x07 bits 4:0 select the sources of pins 1 and 2. The codes are: 1 to 5 select evt bits 0 to 4; 7 to 12 select evt bits 5 to 10; 13 selects evt[9] OR evt[10]; 15 to 20 select evt bits 11 to 16; 21 selects evt[15] OR evt[16].
- R11: The codes 0, 6, 14 and 22 to 31 hold the pin at its inactive level, whatever the event inputs are.
- R12: Register 0x06 bit 6 sets active-low polarity (idle high) and bit 7 sets open-drain drive, for both pins. In push-pull mode the output enable is always 1 and the output is the active state XOR the polarity bit. In open-drain mode the output enable equals the active state and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks sample bytes as consumed) |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr in the current bank (combinational) |
| smp_update | input | 1 | New sample set available on smp_data |
| smp_data | input | 16*NPAIR | Sample pairs, pair p in bits 16p+15:16p |
| evt | input | 17 | Internal event flags |
| cfg_image | output | 136 | All stored registers, 8 bits each, in slot order 0x04, 0x05, 0x06, 0x07, 0x08, 0x1D, 0x1E, 0x40, 0x41, 0x42, 0x43, bank1 0x6F, bank2 0x30, bank3 0x40 to 0x43 |
| cfg_3wire | output | 1 | Primary port 3-wire select |
| cfg_aux_3wire | output | 1 | Secondary port 3-wire select |
| cfg_auto_inc | output | 1 | Address auto-increment enable |
| cfg_bdu | output | 1 | Block-update enable |
| cfg_reload | output | 1 | Reload in progress |
| irq1_out | output | 1 | Pin 1 driven value |
| irq1_oe | output | 1 | Pin 1 output enable |
| irq2_out | output | 1 | Pin 2 driven value |
| irq2_oe | output | 1 | Pin 2 output enable |

## Verification
On every cycle the assertions check the following: the identity byte is fixed, 0x7F only ever reads one of the four keys, and a key write lands one cycle later. They also check when the reload starts and that it lasts the exact length, and that the pin drive obeys the push-pull and open-drain rules. They cannot show that a byte held in a special bank survives a bank round trip, that a reload restores those bytes, or that block-update holds a pair across refreshes until both halves are read. Those behaviours need ordered sequences of writes, reads and sample pulses, which only the bench scenarios and its cycle-by-cycle reference model follow.

// File: rtl/sensor_regfile_pkg.sv
package sensor_regfile_pkg;

    localparam int NSLOT = 17;
    localparam int NEVT  = 17;

    typedef enum logic [1:0] {BANK_GEN, BANK_S1, BANK_S2, BANK_S3} bank_e;

    localparam logic [6:0] ADDR_BANKSEL = 7'h7F;
    localparam logic [6:0] ADDR_ID      = 7'h01;
    localparam logic [6:0] ADDR_SMP0    = 7'h0C;
    localparam logic [7:0] ID_VALUE     = 8'h6A;

    localparam logic [4:0] SLOT_COM      = 5'd1;
    localparam int         SLOT_IRQ1     = 2;
    localparam int         SLOT_IRQ2     = 3;
    localparam int         SLOT_SPECIAL0 = 11;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } slot_t;

    typedef struct packed {
        logic       ok;
        bank_e      bank;
    } keydec_t;

    typedef struct packed {
        logic       reload;
        logic       spare;
        logic       bdu;
        logic       auto_inc;
        logic [1:0] rsv;
        logic       aux_3wire;
        logic       pri_3wire;
    } com_t;

    typedef struct packed {
        logic       open_drain;
        logic       act_low;
        logic       rsv;
        logic [4:0] sel;
    } irqcfg_t;

    function automatic slot_t slot_lookup(bank_e b, logic [6:0] a);
        slot_t s;
        s = '{hit: 1'b1, idx: 5'd0};
        unique case (b)
            BANK_GEN: case (a)
                7'h04: s.idx = 5'd0;
                7'h05: s.idx = 5'd1;
                7'h06: s.idx = 5'd2;
                7'h07: s.idx = 5'd3;
                7'h08: s.idx = 5'd4;
                7'h1D: s.idx = 5'd5;
                7'h1E: s.idx = 5'd6;
                7'h40: s.idx = 5'd7;
                7'h41: s.idx = 5'd8;
                7'h42: s.idx = 5'd9;
                7'h43: s.idx = 5'd10;
                default: s.hit = 1'b0;
            endcase
            BANK_S1: if (a == 7'h6F) s.idx = 5'd11; else s.hit = 1'b0;
            BANK_S2: if (a == 7'h30) s.idx = 5'd12; else s.hit = 1'b0;
            BANK_S3: if (a >= 7'h40 && a <= 7'h43) s.idx = 5'd13 + {3'b000, a[1:0]};
                     else s.hit = 1'b0;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] slot_default(int idx);
        case (idx)
            1:  return 8'h50;
            4:  return 8'h80;
            5:  return 8'h07;
            6:  return 8'hFF;
            7:  return 8'hA8;
            8:  return 8'h02;
            9:  return 8'hA9;
            13: return 8'h52;
            14: return 8'h9A;
            15: return 8'h04;
            16: return 8'h57;
            default: return 8'h00;
        endcase
    endfunction

    function automatic keydec_t key_decode(logic [7:0] k);
        case (k)
            8'h00:   return '{ok: 1'b1, bank: BANK_GEN};
            8'h83:   return '{ok: 1'b1, bank: BANK_S1};
            8'h8C:   return '{ok: 1'b1, bank: BANK_S2};
            8'h90:   return '{ok: 1'b1, bank: BANK_S3};
            default: return '{ok: 1'b0, bank: BANK_GEN};
        endcase
    endfunction

    function automatic logic [7:0] bank_key(bank_e b);
        case (b)
            BANK_S1: return 8'h83;
            BANK_S2: return 8'h8C;
            BANK_S3: return 8'h90;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic src_active(logic [4:0] code, logic [NEVT-1:0] e);
        case (code)
            5'd1, 5'd2, 5'd3, 5'd4, 5'd5:          return e[code - 5'd1];
            5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return e[code - 5'd2];
            5'd13:                                  return e[9] | e[10];
            5'd15, 5'd16, 5'd17, 5'd18, 5'd19, 5'd20: return e[code - 5'd4];
            5'd21:                                  return e[15] | e[16];
            default:                                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sensor_regfile_store.sv
module sensor_regfile_store
    import sensor_regfile_pkg::*;
#(
    parameter int RELOAD_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [6:0]           addr,
    input  logic [7:0]           wdata,
    output bank_e                bank,
    output logic [NSLOT*8-1:0]   image,
    output logic                 busy
);
    localparam int CW = $clog2(RELOAD_CYCLES + 1);

    logic [7:0]    slot_q [NSLOT];
    logic [CW-1:0] cnt_q;
    bank_e         bank_q;
    slot_t         wsel;
    keydec_t       kdec;
    logic          start;

    assign wsel  = slot_lookup(bank_q, addr);
    assign kdec  = key_decode(wdata);
    assign start = wr && wsel.hit && (wsel.idx == SLOT_COM) && wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_GEN;
            cnt_q  <= '0;
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= slot_default(i);
        end else begin
            if (wr && addr == ADDR_BANKSEL && kdec.ok) bank_q <= kdec.bank;
            if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
            else if (start)   cnt_q <= CW'(RELOAD_CYCLES);
            for (int i = 0; i < NSLOT; i++) begin
                if (cnt_q == CW'(1) && i >= SLOT_SPECIAL0)
                    slot_q[i] <= slot_default(i);
                else if (wr && wsel.hit && wsel.idx == 5'(i))
                    slot_q[i] <= (5'(i) == SLOT_COM) ? {1'b0, wdata[6:0]} : wdata;
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_img
        assign image[g*8 +: 8] = slot_q[g];
    end

    assign bank = bank_q;
    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sensor_regfile_bdu.sv
module sensor_regfile_bdu #(
    parameter int NPAIR = 6,
    localparam int IW   = $clog2(2 * NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bdu_en,
    input  logic                 smp_update,
    input  logic [16*NPAIR-1:0]  smp_data,
    input  logic                 rd_hit,
    input  logic [IW-1:0]        rd_idx,
    output logic [16*NPAIR-1:0]  shadow
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [15:0] word_q;
        logic        fresh_q, hi_q, lo_q;
        logic        rd_hi, rd_lo, hi_n, lo_n, take;

        assign rd_hi = rd_hit && (rd_idx == IW'(2*p));
        assign rd_lo = rd_hit && (rd_idx == IW'(2*p + 1));
        assign hi_n  = hi_q | rd_hi;
        assign lo_n  = lo_q | rd_lo;
        assign take  = smp_update && (!bdu_en || !fresh_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q  <= '0;
                fresh_q <= 1'b0;
                hi_q    <= 1'b0;
                lo_q    <= 1'b0;
            end else if (take) begin
                word_q  <= smp_data[16*p +: 16];
                fresh_q <= 1'b1;
                hi_q    <= 1'b0;
                lo_q    <= 1'b0;
            end else if (hi_n && lo_n) begin
                fresh_q <= 1'b0;
                hi_q    <= 1'b0;
                lo_q    <= 1'b0;
            end else begin
                hi_q    <= hi_n;
                lo_q    <= lo_n;
            end
        end

        assign shadow[16*p +: 16] = word_q;
    end
endmodule

// File: rtl/sensor_regfile_irq.sv
module sensor_regfile_irq
    import sensor_regfile_pkg::*;
(
    input  logic [NEVT-1:0] evt,
    input  logic [4:0]      sel,
    input  logic            act_low,
    input  logic            open_drain,
    output logic            pin_out,
    output logic            pin_oe
);
    logic active;

    assign active  = src_active(sel, evt);
    assign pin_out = open_drain ? 1'b0   : (active ^ act_low);
    assign pin_oe  = open_drain ? active : 1'b1;
endmodule

// File: rtl/sensor_regfile.sv
module sensor_regfile
    import sensor_regfile_pkg::*;
#(
    parameter int NPAIR         = 6,
    parameter int RELOAD_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [6:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  smp_update,
    input  logic [16*NPAIR-1:0]   smp_data,
    input  logic [NEVT-1:0]       evt,
    output logic [NSLOT*8-1:0]    cfg_image,
    output logic                  cfg_3wire,
    output logic                  cfg_aux_3wire,
    output logic                  cfg_auto_inc,
    output logic                  cfg_bdu,
    output logic                  cfg_reload,
    output logic                  irq1_out,
    output logic                  irq1_oe,
    output logic                  irq2_out,
    output logic                  irq2_oe
);
    localparam int         IW      = $clog2(2 * NPAIR);
    localparam logic [6:0] SMP_END = ADDR_SMP0 + 7'(2 * NPAIR);

    bank_e              bank;
    logic               busy;
    logic [7:0]         cur_key;
    com_t               com;
    irqcfg_t            icfg;
    slot_t              rsel;
    logic               in_smp;
    logic [IW-1:0]      rd_idx;
    logic [16*NPAIR-1:0] shadow;
    logic [15:0]        pair_word;
    logic [4:0]         pin_sel [2];
    logic [1:0]         pin_out, pin_oe;

    sensor_regfile_store #(.RELOAD_CYCLES(RELOAD_CYCLES)) u_store (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .bank(bank), .image(cfg_image), .busy(busy)
    );

    assign in_smp = (bank == BANK_GEN) && (reg_addr >= ADDR_SMP0) && (reg_addr < SMP_END);
    assign rd_idx = IW'(reg_addr - ADDR_SMP0);

    sensor_regfile_bdu #(.NPAIR(NPAIR)) u_bdu (
        .clk(clk), .rst(rst), .bdu_en(com.bdu), .smp_update(smp_update),
        .smp_data(smp_data), .rd_hit(reg_rd && in_smp), .rd_idx(rd_idx),
        .shadow(shadow)
    );

    assign cur_key   = bank_key(bank);
    assign rsel      = slot_lookup(bank, reg_addr);
    assign pair_word = shadow[{rd_idx[IW-1:1], 4'b0000} +: 16];

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_BANKSEL)
            reg_rdata = cur_key;
        else if (bank == BANK_GEN && reg_addr == ADDR_ID)
            reg_rdata = ID_VALUE;
        else if (in_smp)
            reg_rdata = rd_idx[0] ? pair_word[7:0] : pair_word[15:8];
        else if (rsel.hit) begin
            reg_rdata = cfg_image[{rsel.idx, 3'b000} +: 8];
            if (rsel.idx == SLOT_COM) reg_rdata[7] = busy;
        end
    end

    assign com           = com_t'(cfg_image[SLOT_COM*8 +: 8]);
    assign cfg_bdu       = com.bdu;
    assign cfg_auto_inc  = com.auto_inc;
    assign cfg_aux_3wire = com.aux_3wire;
    assign cfg_3wire     = com.pri_3wire;
    assign cfg_reload    = busy;

    assign icfg       = irqcfg_t'(cfg_image[SLOT_IRQ1*8 +: 8]);
    assign pin_sel[0] = icfg.sel;
    assign pin_sel[1] = cfg_image[SLOT_IRQ2*8 +: 5];

    for (genvar g = 0; g < 2; g++) begin : g_pin
        sensor_regfile_irq u_irq (
            .evt(evt), .sel(pin_sel[g]), .act_low(icfg.act_low),
            .open_drain(icfg.open_drain), .pin_out(pin_out[g]), .pin_oe(pin_oe[g])
        );
    end

    assign irq1_out = pin_out[0];
    assign irq1_oe  = pin_oe[0];
    assign irq2_out = pin_out[1];
    assign irq2_oe  = pin_oe[1];
endmodule

// File: rtl/sensor_regfile_chk.sv
module sensor_regfile_chk #(
    parameter int RELOAD_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [6:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [7:0] cur_key,
    input logic       cfg_reload,
    input logic       od_mode,
    input logic       irq1_out,
    input logic       irq1_oe,
    input logic       irq2_out,
    input logic       irq2_oe
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= '0;
        else if (cfg_reload) run_len <= run_len + 16'd1;
        else                 run_len <= '0;
    end

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 7'h01 && cur_key == 8'h00) |-> reg_rdata == 8'h6A); // R2

    AST_KEY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 7'h7F) |-> (reg_rdata == 8'h00 || reg_rdata == 8'h83 ||
                                 reg_rdata == 8'h8C || reg_rdata == 8'h90)); // R3

    AST_KEY_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 7'h7F && reg_wdata == 8'h90) |=> cur_key == 8'h90); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 7'h00) |-> reg_rdata == 8'h00); // R5

    AST_RELOAD_START: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 7'h05 && cur_key == 8'h00 && reg_wdata[7] && !cfg_reload)
        |=> cfg_reload); // R6

    AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_reload) |-> run_len == 16'(RELOAD_CYCLES)); // R6

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        od_mode |-> ((!irq1_oe || !irq1_out) && (!irq2_oe || !irq2_out))); // R12

    AST_PP_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        !od_mode |-> (irq1_oe && irq2_oe)); // R12
endmodule

bind sensor_regfile sensor_regfile_chk #(.RELOAD_CYCLES(RELOAD_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_key(cur_key),
    .cfg_reload(cfg_reload), .od_mode(cfg_image[sensor_regfile_pkg::SLOT_IRQ1*8+7]),
    .irq1_out(irq1_out), .irq1_oe(irq1_oe), .irq2_out(irq2_out), .irq2_oe(irq2_oe)
);

// File: tb/test_sensor_regfile.sv
module test_sensor_regfile;
    localparam int NPAIR = 6;
    localparam int RL    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              reg_wr = 0, reg_rd = 0, smp_update = 0;
    logic [6:0]        reg_addr = 7'h00;
    logic [7:0]        reg_wdata = 8'h00;
    logic [16*NPAIR-1:0] smp_data = '0;
    logic [16:0]       evt = '0;
    logic [7:0]        reg_rdata;
    logic [135:0]      cfg_image;
    logic cfg_3wire, cfg_aux_3wire, cfg_auto_inc, cfg_bdu, cfg_reload;
    logic irq1_out, irq1_oe, irq2_out, irq2_oe;

    sensor_regfile #(.NPAIR(NPAIR), .RELOAD_CYCLES(RL)) i_sensor_regfile (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_update(smp_update),
        .smp_data(smp_data), .evt(evt), .cfg_image(cfg_image), .cfg_3wire(cfg_3wire),
        .cfg_aux_3wire(cfg_aux_3wire), .cfg_auto_inc(cfg_auto_inc), .cfg_bdu(cfg_bdu),
        .cfg_reload(cfg_reload), .irq1_out(irq1_out), .irq1_oe(irq1_oe),
        .irq2_out(irq2_out), .irq2_oe(irq2_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0]  m_reg [4][128];
    bit          m_rw  [4][128];
    int          m_bank, m_cnt;
    logic [15:0] m_sh [NPAIR];
    bit          m_fr [NPAIR];
    bit          m_hs [NPAIR];
    bit          m_ls [NPAIR];

    function automatic void m_restore_special();
        m_reg[1][7'h6F] = 8'h00;
        m_reg[2][7'h30] = 8'h00;
        m_reg[3][7'h40] = 8'h52; m_reg[3][7'h41] = 8'h9A;
        m_reg[3][7'h42] = 8'h04; m_reg[3][7'h43] = 8'h57;
    endfunction

    function automatic void m_reset();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 128; a++) begin m_reg[b][a] = 8'h00; m_rw[b][a] = 0; end
        foreach (m_sh[p]) begin m_sh[p] = 0; m_fr[p] = 0; m_hs[p] = 0; m_ls[p] = 0; end
        m_bank = 0; m_cnt = 0;
        m_rw[0][7'h04] = 1; m_rw[0][7'h05] = 1; m_rw[0][7'h06] = 1; m_rw[0][7'h07] = 1;
        m_rw[0][7'h08] = 1; m_rw[0][7'h1D] = 1; m_rw[0][7'h1E] = 1;
        for (int a = 7'h40; a <= 7'h43; a++) begin m_rw[0][a] = 1; m_rw[3][a] = 1; end
        m_rw[1][7'h6F] = 1; m_rw[2][7'h30] = 1;
        m_reg[0][7'h05] = 8'h50; m_reg[0][7'h08] = 8'h80; m_reg[0][7'h1D] = 8'h07;
        m_reg[0][7'h1E] = 8'hFF; m_reg[0][7'h40] = 8'hA8; m_reg[0][7'h41] = 8'h02;
        m_reg[0][7'h42] = 8'hA9;
        m_restore_special();
    endfunction

    function automatic logic [7:0] m_read(logic [6:0] a);
        int off;
        off = int'(a) - 12;
        if (a == 7'h7F) begin
            case (m_bank) 1: return 8'h83; 2: return 8'h8C; 3: return 8'h90; default: return 8'h00; endcase
        end
        if (m_bank == 0 && a == 7'h01) return 8'h6A;
        if (m_bank == 0 && off >= 0 && off < 2*NPAIR)
            return (off % 2 == 0) ? m_sh[off/2][15:8] : m_sh[off/2][7:0];
        if (m_rw[m_bank][a]) begin
            if (m_bank == 0 && a == 7'h05) return {(m_cnt != 0), m_reg[0][a][6:0]};
            return m_reg[m_bank][a];
        end
        return 8'h00;
    endfunction

    function automatic bit ev_pick(logic [4:0] c, logic [16:0] e);
        case (c)
            1: return e[0];  2: return e[1];  3: return e[2];  4: return e[3];  5: return e[4];
            7: return e[5];  8: return e[6];  9: return e[7];  10: return e[8]; 11: return e[9];
            12: return e[10]; 13: return e[9] | e[10];
            15: return e[11]; 16: return e[12]; 17: return e[13]; 18: return e[14];
            19: return e[15]; 20: return e[16]; 21: return e[15] | e[16];
            default: return 0;
        endcase
    endfunction

    function automatic void m_step();
        bit bdu;
        int old_cnt;
        bdu = m_reg[0][7'h05][5];
        for (int p = 0; p < NPAIR; p++) begin
            bit rh, rl;
            rh = reg_rd && m_bank == 0 && reg_addr == 7'(12 + 2*p);
            rl = reg_rd && m_bank == 0 && reg_addr == 7'(13 + 2*p);
            if (smp_update && (!bdu || !m_fr[p])) begin
                m_sh[p] = smp_data[16*p +: 16]; m_fr[p] = 1; m_hs[p] = 0; m_ls[p] = 0;
            end else begin
                m_hs[p] |= rh; m_ls[p] |= rl;
                if (m_hs[p] && m_ls[p]) begin m_fr[p] = 0; m_hs[p] = 0; m_ls[p] = 0; end
            end
        end
        old_cnt = m_cnt;
        if (reg_wr) begin
            if (reg_addr == 7'h7F) begin
                case (reg_wdata)
                    8'h00: m_bank = 0; 8'h83: m_bank = 1; 8'h8C: m_bank = 2; 8'h90: m_bank = 3;
                    default: ;
                endcase
            end else if (m_rw[m_bank][reg_addr]) begin
                if (m_bank == 0 && reg_addr == 7'h05) begin
                    m_reg[0][7'h05] = reg_wdata & 8'h7F;
                end else begin
                    m_reg[m_bank][reg_addr] = reg_wdata;
                end
            end
        end
        if (old_cnt != 0) begin
            if (old_cnt == 1) m_restore_special();
            m_cnt = old_cnt - 1;
        end else if (reg_wr && reg_addr == 7'h05 && reg_wdata[7] && m_rw[0][7'h05] && m_bank == 0) begin
            m_cnt = RL;
        end
    endfunction

    always @(posedge clk) begin
        if (rst) m_reset();
        else     m_step();
    end

    // every-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            logic [7:0] c6, c5;
            bit a1, a2, eo1, eo2, ee1, ee2;
            c6 = m_reg[0][7'h06];
            c5 = m_reg[0][7'h05];
            a1 = ev_pick(c6[4:0], evt);
            a2 = ev_pick(m_reg[0][7'h07][4:0], evt);
            eo1 = c6[7] ? 1'b0 : (a1 ^ c6[6]);  ee1 = c6[7] ? a1 : 1'b1;
            eo2 = c6[7] ? 1'b0 : (a2 ^ c6[6]);  ee2 = c6[7] ? a2 : 1'b1;
            chk(reg_rdata == m_read(reg_addr), "R5", "model rdata", reg_rdata, m_read(reg_addr));
            chk({irq1_out, irq1_oe, irq2_out, irq2_oe} == {eo1, ee1, eo2, ee2}, "R12", "model pins",
                {irq1_out, irq1_oe, irq2_out, irq2_oe}, {eo1, ee1, eo2, ee2});
            chk({cfg_bdu, cfg_auto_inc, cfg_aux_3wire, cfg_3wire} == {c5[5], c5[4], c5[1], c5[0]},
                "R7", "model com fields", {cfg_bdu, cfg_auto_inc, cfg_aux_3wire, cfg_3wire},
                {c5[5], c5[4], c5[1], c5[0]});
            chk(cfg_reload == (m_cnt != 0), "R6", "model reload", cfg_reload, (m_cnt != 0));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(logic [6:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [6:0] a, logic [7:0] exp, string req);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        #1 chk(reg_rdata == exp, req, $sformatf("read 0x%02h", a), reg_rdata, exp);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic upd(logic [16*NPAIR-1:0] d);
        @(negedge clk); smp_data = d; smp_update = 1;
        @(negedge clk); smp_update = 0;
    endtask

    task automatic pins(logic [16:0] e, logic [3:0] exp, string req);
        @(negedge clk); evt = e;
        #1 chk({irq1_out, irq1_oe, irq2_out, irq2_oe} == exp, req, "pins out1,oe1,out2,oe2",
               {irq1_out, irq1_oe, irq2_out, irq2_oe}, exp);
    endtask

    function automatic logic [16*NPAIR-1:0] mk(logic [7:0] s);
        logic [16*NPAIR-1:0] v;
        for (int p = 0; p < NPAIR; p++) v[16*p +: 16] = {s + 8'(p), ~s - 8'(p)};
        return v;
    endfunction

    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [16*NPAIR-1:0] sa, sb, sc;
        sa = mk(8'h11); sb = mk(8'h5A); sc = mk(8'hC3);
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(7'h05, 8'h50, "R1"); rd(7'h08, 8'h80, "R1"); rd(7'h1D, 8'h07, "R1");
        rd(7'h1E, 8'hFF, "R1"); rd(7'h40, 8'hA8, "R1"); rd(7'h41, 8'h02, "R1");
        rd(7'h42, 8'hA9, "R1"); rd(7'h06, 8'h00, "R1"); rd(7'h7F, 8'h00, "R1");
        chk(cfg_auto_inc == 1'b1, "R1", "auto-inc after reset", cfg_auto_inc, 1);
        pins(17'h1FFFF, 4'b0101, "R1");

        // R2 identity
        rd(7'h01, 8'h6A, "R2");
        wr(7'h01, 8'h00);
        rd(7'h01, 8'h6A, "R2");

        // R5 unmapped and read-only
        wr(7'h02, 8'h33); rd(7'h02, 8'h00, "R5");
        wr(7'h0C, 8'hEE); rd(7'h0C, 8'h00, "R5");

        // R3 / R4 banks
        wr(7'h7F, 8'h90); rd(7'h7F, 8'h90, "R3");
        rd(7'h40, 8'h52, "R4"); rd(7'h43, 8'h57, "R4");
        wr(7'h40, 8'h11); rd(7'h40, 8'h11, "R4");
        rd(7'h01, 8'h00, "R5");
        wr(7'h7F, 8'h55); rd(7'h7F, 8'h90, "R3");
        wr(7'h7F, 8'h83); rd(7'h7F, 8'h83, "R3");
        wr(7'h6F, 8'h3C); rd(7'h6F, 8'h3C, "R4");
        wr(7'h7F, 8'h8C); rd(7'h30, 8'h00, "R4");
        wr(7'h30, 8'hA5); rd(7'h30, 8'hA5, "R4");
        rd(7'h6F, 8'h00, "R5");
        wr(7'h7F, 8'h00); rd(7'h7F, 8'h00, "R3");
        rd(7'h40, 8'hA8, "R4"); rd(7'h6F, 8'h00, "R5");

        // R6 reload
        wr(7'h05, 8'hD0);
        rd(7'h05, 8'hD0, "R6");
        chk(cfg_reload == 1'b1, "R6", "reload running", cfg_reload, 1);
        repeat (RL + 2) @(negedge clk);
        rd(7'h05, 8'h50, "R6");
        wr(7'h7F, 8'h90); rd(7'h40, 8'h52, "R6");
        wr(7'h7F, 8'h83); rd(7'h6F, 8'h00, "R6");
        wr(7'h7F, 8'h00);

        // R7 com fields
        wr(7'h05, 8'h23);
        #1 chk({cfg_bdu, cfg_auto_inc, cfg_aux_3wire, cfg_3wire} == 4'b1011, "R7", "com fields",
               {cfg_bdu, cfg_auto_inc, cfg_aux_3wire, cfg_3wire}, 4'b1011);

        // R8 samples without block update
        wr(7'h05, 8'h10);
        upd(sa);
        rd(7'h0C, sa[15:8], "R8"); rd(7'h17, sa[87:80], "R8");
        upd(sb);
        rd(7'h0D, sb[7:0], "R8"); rd(7'h0E, sb[31:24], "R8");

        // R9 block update
        wr(7'h05, 8'h30);
        rd(7'h0C, sb[15:8], "R9"); rd(7'h0D, sb[7:0], "R9");
        upd(sa);
        rd(7'h0C, sa[15:8], "R9");
        upd(sb);
        rd(7'h0D, sa[7:0], "R9");
        upd(sc);
        rd(7'h0C, sc[15:8], "R9");
        wr(7'h05, 8'h10);

        // R10 source routing
        wr(7'h06, 8'h01);
        pins(17'h00000, 4'b0101, "R10");
        pins(17'h00001, 4'b1101, "R10");
        wr(7'h06, 8'h0D);
        pins(17'h00400, 4'b1101, "R10");
        pins(17'h00200, 4'b1101, "R10");
        wr(7'h07, 8'h15);
        pins(17'h10000, 4'b0111, "R10");
        wr(7'h07, 8'h03);
        pins(17'h00004, 4'b0111, "R10");

        // R11 unassigned codes
        wr(7'h06, 8'h06); wr(7'h07, 8'h00);
        pins(17'h1FFFF, 4'b0101, "R11");
        wr(7'h06, 8'h1F);
        pins(17'h1FFFF, 4'b0101, "R11");

        // R12 polarity and drive
        wr(7'h06, 8'h41); wr(7'h07, 8'h15);
        pins(17'h00000, 4'b1111, "R12");
        pins(17'h00001, 4'b0111, "R12");
        wr(7'h06, 8'h81);
        pins(17'h00000, 4'b0000, "R12");
        pins(17'h00001, 4'b0100, "R12");
        pins(17'h10000, 4'b0001, "R12");

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule